// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers the two asynchronous interrupt sources of a small processor core, a timer-tick event from the decrementer and an external interrupt line, and turns them into one delivery request with a cause code. The decrementer is edge sensitive. Its edges are captured into a sticky pending bit, and any number of edges that arrive before delivery collapse into a single interrupt. The external source is level sensitive and is never stored. It counts as pending only while the line is high, so a pulse that rises and falls while interrupts are masked leaves no trace.

Delivery is gated by the interrupt-enable bit of the machine state register. The request is re-evaluated combinationally every cycle, so raising the enable makes an already pending source visible at once. When the core accepts a request, the block blocks the effective enable. This models the hardware clearing the enable on interrupt entry. The block stays blocked until software writes the enable again, which is signalled by a write strobe. When both sources can be delivered at the same time, the decrementer wins.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the decrementer pending bit. In the first cycle after reset is released, `irq_req_o` is 0 and `pend_vec_o[1]` is 0.
- R2: `pend_vec_o` bit 0 (value 1) is the external source. It equals `ext_lvl_i` in the same cycle, whether or not the source is enabled.
- R3: A rising edge of `dec_evt_i` that is sampled at a clock edge sets `pend_vec_o` bit 1 (value 2) from that clock edge onward.
- R4: Several decrementer edges that arrive before a delivery produce exactly one request. After that request is accepted, no further decrementer request follows unless a new edge arrives.
- R5: `irq_req_o` is high exactly when the effective enable is high and at least one pending bit is set. It is never high while `msr_ie_i` is 0. A change of `msr_ie_i` to 1 raises the request in that same cycle if a source is pending.
- R6: An external pulse that rises and falls while `msr_ie_i` is 0 never yields a request after the enable returns.
- R7: `irq_cause_o` is 2'b10 when the decrementer is delivered, 2'b01 when the external source is delivered, and 2'b00 when there is no request. The decrementer is chosen whenever both sources are pending.
- R8: Acceptance (`irq_req_o` and `irq_ack_i` both high) of a decrementer request clears pending bit 1 at that edge. If a new decrementer edge arrives in the same cycle, the bit stays set.
- R9: Accepting an external request leaves `pend_vec_o` bit 0 following the live level.
- R10: After any acceptance, `irq_req_o` stays low until a cycle with `msr_ie_wr_i` high has passed. From the next cycle, delivery resumes according to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_evt_i | input | 1 | Decrementer event, edge sensitive |
| ext_lvl_i | input | 1 | External interrupt level |
| msr_ie_i | input | 1 | Interrupt-enable bit of the machine state register |
| msr_ie_wr_i | input | 1 | Strobe: software wrote the enable bit this cycle |
| irq_ack_i | input | 1 | Core accepts the current request |
| irq_req_o | output | 1 | Delivery request |
| irq_cause_o | output | 2 | Cause: 2'b10 decrementer, 2'b01 external, 2'b00 none |
| pend_vec_o | output | 2 | Pending vector: bit 1 decrementer, bit 0 external |

## Verification
The external level, the enable input and the cause reach the outputs in the same cycle they are driven. A decrementer edge, an acceptance and an enable write take effect one clock edge later. The bench drives each cycle's inputs at the falling edge and pushes the outputs expected for that same cycle into a scoreboard queue. The monitor pops and compares them shortly after, before the rising edge. Scenarios therefore check a registered effect in the step that follows its cause. These scenarios are coalesced edges, a masked external pulse, simultaneous acceptance and re-edge, and the block after acceptance.

// File: rtl/irq_pend_pkg.sv
// Shared constants and types for the masked interrupt pending controller.
// Assumes two sources: external level on bit 0, decrementer on bit 1.
package irq_pend_pkg;
    localparam int unsigned NSRC    = 2;
    localparam int unsigned EXT_BIT = 0;
    localparam int unsigned DEC_BIT = 1;

    typedef enum logic [NSRC-1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_EXT  = 2'b01,
        CAUSE_DEC  = 2'b10
    } irq_cause_e;
endpackage

// File: rtl/irq_dec_capture.sv
// Captures decrementer events into a sticky pending bit.
// Assumes clr_i is only asserted while the bit is being delivered.
// EDGE_DETECT=1 reacts to rising edges; 0 treats each high cycle as an event.
module irq_dec_capture #(
    parameter bit EDGE_DETECT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o
);
    logic evt_hit;
    logic pend_q;

    generate
        if (EDGE_DETECT) begin : g_edge
            logic evt_prev_q;
            // Remember last sampled event level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) evt_prev_q <= 1'b0;
                else        evt_prev_q <= evt_i;
            end
            assign evt_hit = evt_i & ~evt_prev_q;
        end else begin : g_level
            assign evt_hit = evt_i;
        end
    endgenerate

    // Sticky pending bit: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~clr_i) | evt_hit;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_enable_gate.sv
// Derives the effective interrupt enable from the state-register bit.
// Blocks delivery after an acceptance until software writes the enable.
// Also holds delivery off in the first cycle after reset release.
module irq_enable_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_i,
    input  logic ie_wr_i,
    input  logic accept_i,
    output logic eff_en_o
);
    logic run_q;
    logic blk_q;

    // Marks that at least one clock edge has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Entry block: set on acceptance, released by a software enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)        blk_q <= 1'b0;
        else if (ie_wr_i)  blk_q <= 1'b0;
        else if (accept_i) blk_q <= 1'b1;
    end

    assign eff_en_o = run_q & ie_i & ~blk_q;
endmodule

// File: rtl/irq_select.sv
// Fixed-priority selection of the source to deliver.
// Assumes pend_i uses the package bit positions; decrementer outranks external.
module irq_select
    import irq_pend_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic            en_i,
    output logic            req_o,
    output irq_cause_e      cause_o
);
    // Pick the highest-priority pending source when enabled.
    always_comb begin
        req_o   = 1'b0;
        cause_o = CAUSE_NONE;
        if (en_i) begin
            if (pend_i[DEC_BIT]) begin
                req_o   = 1'b1;
                cause_o = CAUSE_DEC;
            end else if (pend_i[EXT_BIT]) begin
                req_o   = 1'b1;
                cause_o = CAUSE_EXT;
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
// Masked interrupt pending controller: edge-captured decrementer plus live
// external level, gated by the state-register enable, single request out.
// Assumes irq_ack_i is only meaningful while irq_req_o is high.
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter bit DEC_EDGE_DETECT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_evt_i,
    input  logic            ext_lvl_i,
    input  logic            msr_ie_i,
    input  logic            msr_ie_wr_i,
    input  logic            irq_ack_i,
    output logic            irq_req_o,
    output logic [NSRC-1:0] irq_cause_o,
    output logic [NSRC-1:0] pend_vec_o
);
    logic       dec_pend;
    logic       dec_clr;
    logic       accept;
    logic       eff_en;
    irq_cause_e cause;

    // Handshake completes when a request meets an acknowledge.
    assign accept  = irq_req_o & irq_ack_i;
    assign dec_clr = accept & (cause == CAUSE_DEC);

    irq_dec_capture #(.EDGE_DETECT(DEC_EDGE_DETECT)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (dec_evt_i),
        .clr_i  (dec_clr),
        .pend_o (dec_pend)
    );

    irq_enable_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_i     (msr_ie_i),
        .ie_wr_i  (msr_ie_wr_i),
        .accept_i (accept),
        .eff_en_o (eff_en)
    );

    // Assemble the pending vector; the external bit is never stored.
    always_comb begin
        pend_vec_o          = '0;
        pend_vec_o[DEC_BIT] = dec_pend;
        pend_vec_o[EXT_BIT] = ext_lvl_i;
    end

    irq_select u_sel (
        .pend_i  (pend_vec_o),
        .en_i    (eff_en),
        .req_o   (irq_req_o),
        .cause_o (cause)
    );

    assign irq_cause_o = cause;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
// Property checker for irq_pend_ctrl; attached through bind below.
module irq_pend_ctrl_chk
    import irq_pend_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            dec_evt_i,
    input logic            msr_ie_i,
    input logic            msr_ie_wr_i,
    input logic            irq_ack_i,
    input logic            irq_req_o,
    input logic [NSRC-1:0] irq_cause_o,
    input logic [NSRC-1:0] pend_vec_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_req_o && !pend_vec_o[DEC_BIT]));

    // R3
    dec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_evt_i) |=> pend_vec_o[DEC_BIT]);

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msr_ie_i |-> !irq_req_o);

    // R7
    dec_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && pend_vec_o[DEC_BIT]) |-> (irq_cause_o == 2'b10));

    // R7
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> (irq_cause_o == 2'b00));

    // R8
    dec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i && irq_cause_o == 2'b10 && !dec_evt_i)
        |=> !pend_vec_o[DEC_BIT]);

    // R10
    entry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i && !msr_ie_wr_i) |=> !irq_req_o);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_evt_i   (dec_evt_i),
    .msr_ie_i    (msr_ie_i),
    .msr_ie_wr_i (msr_ie_wr_i),
    .irq_ack_i   (irq_ack_i),
    .irq_req_o   (irq_req_o),
    .irq_cause_o (irq_cause_o),
    .pend_vec_o  (pend_vec_o)
);

// File: tb/irq_pend_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes each cycle's expected outputs,
// the monitor pops and compares them before the next rising edge.
module irq_pend_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_evt = 1'b0;
    logic       ext_lvl = 1'b0;
    logic       msr_ie = 1'b0;
    logic       msr_ie_wr = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [1:0] irq_cause;
    logic [1:0] pend_vec;

    typedef struct packed {
        logic       req;
        logic [1:0] cause;
        logic [1:0] pend;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    event  mon_ev;

    always #2 clk = ~clk;   // 250 MHz

    irq_pend_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_evt_i   (dec_evt),
        .ext_lvl_i   (ext_lvl),
        .msr_ie_i    (msr_ie),
        .msr_ie_wr_i (msr_ie_wr),
        .irq_ack_i   (irq_ack),
        .irq_req_o   (irq_req),
        .irq_cause_o (irq_cause),
        .pend_vec_o  (pend_vec)
    );

    // Monitor: compare live outputs against the oldest expected item.
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (irq_req !== e.req || irq_cause !== e.cause || pend_vec !== e.pend) begin
                    failures++;
                    $display("FAIL %s: req/cause/pend actual=%b/%b/%b expected=%b/%b/%b",
                             t, irq_req, irq_cause, pend_vec, e.req, e.cause, e.pend);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, optionally with an expected item.
    task automatic step(input logic rst, input logic dec, input logic ext,
                        input logic ie, input logic wr, input logic ack,
                        input logic chk, input logic er, input logic [1:0] ec,
                        input logic [1:0] ep, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n     = ~rst;
        dec_evt   = dec;
        ext_lvl   = ext;
        msr_ie    = ie;
        msr_ie_wr = wr;
        irq_ack   = ack;
        if (chk) begin
            #1;
            e.req   = er;
            e.cause = ec;
            e.pend  = ep;
            exp_q.push_back(e);
            tag_q.push_back(tag);
            -> mon_ev;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        //    rst dec ext ie wr ack chk req cause pend
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "rst");
        step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, 2'b00, "R1 idle after reset");
        step(0, 0, 1, 0, 0, 0, 1, 0, 2'b00, 2'b01, "R2/R5 ext live but masked");
        step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, 2'b00, "R6 masked pulse gone");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R6 enable after lost pulse");
        step(0, 0, 1, 1, 0, 0, 1, 1, 2'b01, 2'b01, "R5/R7 ext delivered");
        step(0, 0, 1, 1, 0, 1, 1, 1, 2'b01, 2'b01, "R7 ext acked");
        step(0, 0, 1, 1, 0, 0, 1, 0, 2'b00, 2'b01, "R9/R10 blocked, ext still pending");
        step(0, 0, 0, 1, 1, 0, 1, 0, 2'b00, 2'b00, "R2 ext drop during write");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R5 nothing pending");
        // coalesced decrementer edges while masked
        step(0, 1, 0, 0, 1, 0, 1, 0, 2'b00, 2'b00, "R3 edge not yet captured");
        step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, 2'b10, "R3 dec captured");
        step(0, 1, 0, 0, 0, 0, 1, 0, 2'b00, 2'b10, "R4 second edge");
        step(0, 0, 0, 0, 0, 0, 1, 0, 2'b00, 2'b10, "R4 still one bit");
        step(0, 1, 1, 0, 0, 0, 1, 0, 2'b00, 2'b11, "R5 both pending masked");
        step(0, 0, 1, 1, 1, 0, 1, 1, 2'b10, 2'b11, "R5/R7 enable re-eval, dec priority");
        step(0, 0, 1, 1, 0, 1, 1, 1, 2'b10, 2'b11, "R7 dec acked");
        step(0, 0, 1, 1, 0, 0, 1, 0, 2'b00, 2'b01, "R8/R10 dec cleared, blocked");
        step(0, 0, 0, 1, 1, 0, 1, 0, 2'b00, 2'b00, "R10 write enable");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R4 single interrupt only");
        // acceptance together with a new edge
        step(0, 1, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R3 edge while enabled");
        step(0, 0, 0, 1, 0, 0, 1, 1, 2'b10, 2'b10, "R3/R5 dec request");
        step(0, 1, 0, 1, 0, 1, 1, 1, 2'b10, 2'b10, "R8 ack with new edge");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b10, "R8 bit re-set, R10 blocked");
        step(0, 0, 0, 1, 1, 0, 1, 0, 2'b00, 2'b10, "R10 still blocked in write cycle");
        step(0, 0, 0, 1, 0, 0, 1, 1, 2'b10, 2'b10, "R10 delivery resumes");
        step(0, 0, 0, 1, 0, 1, 1, 1, 2'b10, 2'b10, "R8 final ack");
        step(0, 0, 0, 1, 1, 0, 1, 0, 2'b00, 2'b00, "R8 cleared");
        // held event level counts once; then reset mid-run
        step(0, 1, 0, 0, 0, 0, 1, 0, 2'b00, 2'b00, "R3 held level start");
        step(0, 1, 0, 0, 0, 0, 1, 0, 2'b00, 2'b10, "R3 held level captured");
        step(0, 1, 0, 0, 0, 0, 1, 0, 2'b00, 2'b10, "R4 held level no second edge");
        step(1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, "rst");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R1 pending cleared by reset");
        step(0, 0, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, "R1 stays idle");
        step(0, 0, 1, 1, 0, 0, 1, 1, 2'b01, 2'b01, "R5 ext after reset");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule